// File: doc/BRIEF.md
# Wrapped-Order Cache Line Fill Controller

This block handles the refill side of a cache miss. When the cache reports a miss, the controller asks memory for the line that holds the missed word, with the missed word named as the first one to return. Memory then streams the line back one word per beat. Each beat is written into the line buffer at a word slot that starts at the missed word and steps upward, wrapping from the top slot of the line back to slot zero.

The first beat carries the word the processor is waiting for. It is handed to the processor on the same cycle it arrives, so the processor can continue while the other seven words are still arriving. During the fill, a processor access that falls in the line being filled is held off until its word has landed in the buffer. No second miss is taken until the current line is complete. Choosing the way to replace and updating the tag belong to the surrounding cache.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset the controller is idle: `miss_ready` is 1 and `lb_we`, `cpu_data_valid`, `fill_done` and `acc_stall` are 0.
- R2: A miss is taken on a cycle where `miss_valid` and `miss_ready` are both 1. On that same cycle `mem_req_valid` is 1 and `mem_req_addr` equals `miss_addr` with its two byte-select bits cleared. Address bits [4:2] are the critical word slot and bits [31:5] name the line.
- R3: The first response beat of a fill is written to the critical word slot. On that beat only, `cpu_data_valid` is 1 and `cpu_data` carries the beat's data.
- R4: Each later beat is written to the slot one above the previous beat, modulo 8. A fill starting at slot 5 writes slots 5,6,7,0,1,2,3,4.
- R5: `fill_done` is 1 for exactly one cycle per fill: the cycle of the eighth beat. The controller is idle (`miss_ready` = 1) on the following cycle.
- R6: A `rsp_valid` beat that arrives while the controller is idle is ignored: `lb_we` stays 0.
- R7: `acc_stall` is 1 only when `acc_valid` is 1, a fill is in progress, `acc_addr` bits [31:5] match the filling line, and the slot given by `acc_addr` bits [4:2] has not yet been written by an earlier beat. Otherwise it is 0.
- R8: While a fill is in progress `miss_ready` is 0, and a `miss_valid` raised then produces no `mem_req_valid` and leaves the fill order and target line unchanged.
- R9: Cycles with `rsp_valid` low during a fill write nothing and do not advance the slot sequence or the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request from the cache |
| miss_addr | input | 32 | Byte address of the missed word |
| miss_ready | output | 1 | Controller is idle and can take a miss |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_addr | output | 32 | Word-aligned address of the critical word |
| rsp_valid | input | 1 | Memory response beat present |
| rsp_data | input | 32 | Response beat data |
| lb_we | output | 1 | Line buffer word write enable |
| lb_idx | output | 3 | Line buffer word slot |
| lb_wdata | output | 32 | Line buffer write data |
| cpu_data_valid | output | 1 | Early critical word to the processor |
| cpu_data | output | 32 | Critical word data |
| fill_done | output | 1 | Last word of the line written |
| acc_valid | input | 1 | Processor access probe |
| acc_addr | input | 32 | Processor access byte address |
| acc_stall | output | 1 | Access must wait for its word |

## Verification
The checks assume that memory returns exactly eight beats for each accepted miss and never sends a beat for a request that was not made. Stray beats are only sent while the controller is idle, where R6 requires them to be dropped. Under that assumption every fill ends with `fill_done`, and the slot-sequence check may restart its history at that point. The stimulus follows this by giving each fill exactly eight valid beats, with gaps placed between them. Extra misses and processor probes are mixed in so they overlap those eight beats.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_phase_e;

endpackage

// File: rtl/cwf_wrap_seq.sv
// Next word slot and beat count for one accepted response beat.
module cwf_wrap_seq #(
    parameter int OFF_W = 3
) (
    input  logic [OFF_W-1:0] ptr_i,
    input  logic [OFF_W-1:0] cnt_i,
    output logic [OFF_W-1:0] ptr_next_o,
    output logic [OFF_W-1:0] cnt_next_o,
    output logic             first_o,
    output logic             last_o
);
    // The slot width matches the line size, so the increment wraps the line.
    assign ptr_next_o = ptr_i + OFF_W'(1);
    assign cnt_next_o = cnt_i + OFF_W'(1);
    assign first_o    = (cnt_i == '0);
    assign last_o     = &cnt_i;
endmodule

// File: rtl/cwf_word_mask.sv
// Per-slot record of which words of the line have been written.
module cwf_word_mask #(
    parameter int WORDS = 8,
    parameter int OFF_W = $clog2(WORDS)
) (
    input  logic [WORDS-1:0] mask_i,
    input  logic             clear_i,
    input  logic             set_en_i,
    input  logic [OFF_W-1:0] set_idx_i,
    output logic [WORDS-1:0] mask_o
);
    for (genvar w = 0; w < WORDS; w++) begin : g_slot
        always_comb begin
            if (clear_i) begin
                mask_o[w] = 1'b0;
            end else begin
                mask_o[w] = mask_i[w] | (set_en_i && (set_idx_i == OFF_W'(w)));
            end
        end
    end
endmodule

// File: rtl/cwf_hazard.sv
// Hold-off decision for a processor access that hits the line being filled.
module cwf_hazard #(
    parameter int WORDS  = 8,
    parameter int OFF_W  = $clog2(WORDS),
    parameter int LINE_W = 27
) (
    input  logic              busy_i,
    input  logic [LINE_W-1:0] fill_line_i,
    input  logic [WORDS-1:0]  written_i,
    input  logic              acc_valid_i,
    input  logic [LINE_W-1:0] acc_line_i,
    input  logic [OFF_W-1:0]  acc_off_i,
    output logic              stall_o
);
    logic same_line;
    logic word_here;

    assign same_line = (acc_line_i == fill_line_i);
    assign word_here = written_i[acc_off_i];
    assign stall_o   = acc_valid_i & busy_i & same_line & ~word_here;
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
    import cwf_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WORDS    = 8,
    parameter int WORD_BYT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     miss_valid,
    input  logic [ADDR_W-1:0]        miss_addr,
    output logic                     miss_ready,
    output logic                     mem_req_valid,
    output logic [ADDR_W-1:0]        mem_req_addr,
    input  logic                     rsp_valid,
    input  logic [DATA_W-1:0]        rsp_data,
    output logic                     lb_we,
    output logic [$clog2(WORDS)-1:0] lb_idx,
    output logic [DATA_W-1:0]        lb_wdata,
    output logic                     cpu_data_valid,
    output logic [DATA_W-1:0]        cpu_data,
    output logic                     fill_done,
    input  logic                     acc_valid,
    input  logic [ADDR_W-1:0]        acc_addr,
    output logic                     acc_stall
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int BYTE_W = $clog2(WORD_BYT);
    localparam int LINE_W = ADDR_W - OFF_W - BYTE_W;

    typedef struct packed {
        fill_phase_e       phase;
        logic [LINE_W-1:0] line;
        logic [OFF_W-1:0]  ptr;
        logic [OFF_W-1:0]  cnt;
        logic [WORDS-1:0]  written;
    } fill_st_t;

    fill_st_t st_d, st_q;

    // Address fields
    logic [LINE_W-1:0] miss_line, acc_line;
    logic [OFF_W-1:0]  miss_off, acc_off;
    logic              unused_byte_bits;

    assign miss_line        = miss_addr[ADDR_W-1 -: LINE_W];
    assign miss_off         = miss_addr[BYTE_W +: OFF_W];
    assign acc_line         = acc_addr[ADDR_W-1 -: LINE_W];
    assign acc_off          = acc_addr[BYTE_W +: OFF_W];
    assign unused_byte_bits = ^{miss_addr[BYTE_W-1:0], acc_addr[BYTE_W-1:0]};

    // Handshake terms
    logic busy, take_miss, beat;
    assign busy      = (st_q.phase == FILL_BUSY);
    assign take_miss = miss_valid & ~busy;
    assign beat      = rsp_valid & busy;

    // Slot sequencing
    logic [OFF_W-1:0] ptr_nx, cnt_nx;
    logic             first_beat, last_beat;

    cwf_wrap_seq #(.OFF_W(OFF_W)) u_seq (
        .ptr_i      (st_q.ptr),
        .cnt_i      (st_q.cnt),
        .ptr_next_o (ptr_nx),
        .cnt_next_o (cnt_nx),
        .first_o    (first_beat),
        .last_o     (last_beat)
    );

    // Written-slot record
    logic [WORDS-1:0] written_nx;

    cwf_word_mask #(.WORDS(WORDS), .OFF_W(OFF_W)) u_mask (
        .mask_i    (st_q.written),
        .clear_i   (take_miss),
        .set_en_i  (beat),
        .set_idx_i (st_q.ptr),
        .mask_o    (written_nx)
    );

    // Processor access hold-off
    cwf_hazard #(.WORDS(WORDS), .OFF_W(OFF_W), .LINE_W(LINE_W)) u_haz (
        .busy_i      (busy),
        .fill_line_i (st_q.line),
        .written_i   (st_q.written),
        .acc_valid_i (acc_valid),
        .acc_line_i  (acc_line),
        .acc_off_i   (acc_off),
        .stall_o     (acc_stall)
    );

    // Next-state
    always_comb begin
        st_d         = st_q;
        st_d.written = written_nx;
        if (take_miss) begin
            st_d.phase = FILL_BUSY;
            st_d.line  = miss_line;
            st_d.ptr   = miss_off;
            st_d.cnt   = '0;
        end else if (beat) begin
            st_d.ptr = ptr_nx;
            st_d.cnt = cnt_nx;
            if (last_beat) begin
                st_d.phase = FILL_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: FILL_IDLE, line: '0, ptr: '0, cnt: '0, written: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs
    assign miss_ready     = ~busy;
    assign mem_req_valid  = take_miss;
    assign mem_req_addr   = {miss_line, miss_off, {BYTE_W{1'b0}}};
    assign lb_we          = beat;
    assign lb_idx         = st_q.ptr;
    assign lb_wdata       = rsp_data;
    assign cpu_data_valid = beat & first_beat;
    assign cpu_data       = rsp_data;
    assign fill_done      = beat & last_beat;
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int OFF_W  = $clog2(WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_ready,
    input logic              mem_req_valid,
    input logic              lb_we,
    input logic [OFF_W-1:0]  lb_idx,
    input logic [DATA_W-1:0] lb_wdata,
    input logic              cpu_data_valid,
    input logic [DATA_W-1:0] cpu_data,
    input logic              fill_done,
    input logic              acc_stall
);
    logic             have_q;
    logic [OFF_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            last_q <= '0;
        end else if (lb_we) begin
            have_q <= ~fill_done;
            last_q <= lb_idx;
        end
    end

    // R2
    req_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !miss_ready);

    // R3
    early_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_data_valid |-> (lb_we && cpu_data == lb_wdata && !have_q));

    // R4
    wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_we && have_q) |-> (lb_idx == last_q + OFF_W'(1)));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> miss_ready);

    // R6
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready |-> !lb_we);

    // R7
    stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stall |-> !miss_ready);

    // R8
    no_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_ready |-> !mem_req_valid);
endmodule

bind cwf_line_fill cwf_line_fill_chk #(.WORDS(WORDS), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_ready     (miss_ready),
    .mem_req_valid  (mem_req_valid),
    .lb_we          (lb_we),
    .lb_idx         (lb_idx),
    .lb_wdata       (lb_wdata),
    .cpu_data_valid (cpu_data_valid),
    .cpu_data       (cpu_data),
    .fill_done      (fill_done),
    .acc_stall      (acc_stall)
);

// File: tb/cwf_line_fill_tb.sv
module cwf_line_fill_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        miss_ready, mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        lb_we;
    logic [2:0]  lb_idx;
    logic [31:0] lb_wdata;
    logic        cpu_data_valid;
    logic [31:0] cpu_data;
    logic        fill_done;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_stall;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    bit          m_busy = 0;
    logic [26:0] m_line = '0;
    int          m_ptr = 0;
    int          m_cnt = 0;
    bit [7:0]    m_done_set = '0;

    always #10 clk = ~clk;

    cwf_line_fill u_dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .lb_we(lb_we), .lb_idx(lb_idx), .lb_wdata(lb_wdata),
        .cpu_data_valid(cpu_data_valid), .cpu_data(cpu_data),
        .fill_done(fill_done),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_stall(acc_stall)
    );

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One cycle: compare outputs mid-cycle against the model, then advance the model.
    task automatic tick();
        bit beat;
        bit exp_stall;
        #5;
        beat      = m_busy && rsp_valid;
        exp_stall = acc_valid && m_busy && (acc_addr[31:5] == m_line)
                    && !m_done_set[acc_addr[4:2]];
        cmp("R8 miss_ready", {31'd0, miss_ready}, {31'd0, !m_busy});
        cmp("R2 mem_req_valid", {31'd0, mem_req_valid}, {31'd0, miss_valid && !m_busy});
        if (miss_valid && !m_busy)
            cmp("R2 mem_req_addr", mem_req_addr, {miss_addr[31:2], 2'b00});
        cmp("R6/R9 lb_we", {31'd0, lb_we}, {31'd0, beat});
        if (beat) begin
            cmp("R4 lb_idx", {29'd0, lb_idx}, m_ptr);
            cmp("R3 lb_wdata", lb_wdata, rsp_data);
        end
        cmp("R3 cpu_data_valid", {31'd0, cpu_data_valid}, {31'd0, beat && m_cnt == 0});
        if (beat && m_cnt == 0) cmp("R3 cpu_data", cpu_data, rsp_data);
        cmp("R5 fill_done", {31'd0, fill_done}, {31'd0, beat && m_cnt == 7});
        cmp("R7 acc_stall", {31'd0, acc_stall}, {31'd0, exp_stall});
        @(posedge clk);
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_ptr = 0; m_done_set = '0;
        end else if (!m_busy && miss_valid) begin
            m_busy = 1;
            m_line = miss_addr[31:5];
            m_ptr = int'(miss_addr[4:2]);
            m_cnt = 0;
            m_done_set = '0;
        end else if (beat) begin
            m_done_set[m_ptr] = 1'b1;
            m_ptr = (m_ptr + 1) % 8;
            m_cnt++;
            if (m_cnt == 8) m_busy = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        miss_valid = 0; rsp_valid = 0; acc_valid = 0;
    endtask

    // One fill: miss, then eight beats; gap_mask bit k puts an idle cycle before beat k.
    task automatic run_fill(logic [31:0] addr, logic [31:0] base, bit [7:0] gap_mask,
                            logic [31:0] probe, logic [31:0] extra_miss);
        idle_inputs();
        miss_valid = 1; miss_addr = addr;
        tick();
        miss_valid = 0;
        for (int k = 0; k < 8; k++) begin
            if (gap_mask[k]) begin
                rsp_valid = 0;
                acc_valid = 1; acc_addr = probe;
                tick();
            end
            rsp_valid = 1; rsp_data = base + k;
            acc_valid = (k % 2 == 1); acc_addr = probe + 32'(k * 4);
            miss_valid = (k == 3); miss_addr = extra_miss;
            tick();
        end
        idle_inputs();
    endtask

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        // R1: reset state
        #5;
        cmp("R1 ready", {31'd0, miss_ready}, 32'd1);
        cmp("R1 we", {31'd0, lb_we}, 32'd0);
        cmp("R1 cpu_valid", {31'd0, cpu_data_valid}, 32'd0);
        cmp("R1 done", {31'd0, fill_done}, 32'd0);
        cmp("R1 stall", {31'd0, acc_stall}, 32'd0);
        @(negedge clk);
        tick();
        // R6: stray beat while idle
        rsp_valid = 1; rsp_data = 32'hDEAD_BEEF;
        acc_valid = 1; acc_addr = 32'h1000_0030;
        tick(); tick();
        idle_inputs();
        // critical word at slot 5, probes into same line, extra miss ignored (R8)
        run_fill(32'h1000_0036, 32'hA000_0000, 8'h00, 32'h1000_0020, 32'h4444_0000);
        // slot 0, gaps between beats (R9), probes to another line
        run_fill(32'h2000_0000, 32'hB000_0000, 8'b1010_0110, 32'h7000_0000, 32'h5555_0004);
        // slot 7, wraps immediately (R4), probes same line with gaps
        run_fill(32'h3000_001C, 32'hC000_0000, 8'b0101_0011, 32'h3000_0000, 32'h3000_0000);
        // back-to-back fill at slot 3
        run_fill(32'h4000_004C, 32'hD000_0000, 8'h80, 32'h4000_0040, 32'h0);
        tick(); tick();
        finish_run();
    end

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule